// File: doc/BRIEF.md
# Three-Port Bank Access Arbiter

This block decides which of three serial-bus slave front ends may use two 256-byte memory banks at any moment. Each of the two bank ports reaches only its own bank. The control port sees both banks as one 512-byte space and can also reach a small configuration area. Every front end reports the events of its transaction: a decoded device-address byte (a start request, with its direction), the end of the transaction, and the stop that commits a write. The arbiter answers each start request one cycle later. It either holds a grant for the whole session or pulses an acknowledge-suppress so that the front end leaves the address byte unacknowledged.

The arbiter owns the timer for the internal programming cycle. A committed write from any port locks out every port for a programmable number of system clock cycles. A master polls for completion by sending device-address bytes until one is acknowledged. The arbiter also tracks whether the part is in bank mode or combined mode. For the control port it keeps the 9-bit combined address: bit 8 selects the bank and the low byte addresses within that bank. It invalidates this pointer whenever the mode changes, so a read after a switch has to begin with an explicit address.

Top module: `bank_port_arbiter`

## Requirements
- R1: Read requests on both bank ports are granted together when neither the control port nor a write cycle is active. The grants appear in the cycle after the requests.
- R2: A commit from a port that holds a write grant raises `wc_busy` for exactly `WC_CYCLES` cycles, starting the cycle after the commit. The commit also drops every grant, including read grants held by the other bank port.
- R3: A start request from any port while `wc_busy` is high is answered with that port's nack pulse in the next cycle and no grant. The first request after `wc_busy` falls is granted.
- R4: While the control port holds a grant, a start request on a bank port is answered with that port's nack pulse, and the control grant persists.
- R5: While any bank port holds a grant, a control-port start request is nacked. A mode switch therefore only takes effect after the bank session has ended.
- R6: In combined mode, a loaded 9-bit address drives `ctl_bank_sel` from bit 8 (0 selects bank 1, 1 selects bank 2) and `ctl_word_addr` from bits 7..0.
- R7: Incrementing the combined pointer moves from 0FFh to 100h and wraps from 1FFh to 000h.
- R8: After reset the mode is bank mode (`mode_comb`=0) and `ctl_ptr_valid`=0. A grant that changes the mode pulses `mode_switch` for one cycle and clears `ctl_ptr_valid`.
- R9: If the control port and a bank port request a start in the same cycle with no session active, the control port is granted and the bank port is nacked.
- R10: An end event from a granted port drops its grant in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_start | input | 2 | Decoded device-address request, one bit per bank port |
| bank_wr | input | 2 | Direction of the bank request, 1 = write |
| bank_end | input | 2 | Bank port transaction ended (stop or read without acknowledge) |
| bank_commit | input | 2 | Stop after write data; starts programming |
| ctl_start | input | 1 | Control-port device-address request |
| ctl_wr | input | 1 | Direction of the control request, 1 = write |
| ctl_end | input | 1 | Control transaction ended |
| ctl_commit | input | 1 | Control write committed |
| ctl_load | input | 1 | Load the combined pointer |
| ctl_load_addr | input | AW+1 | Combined address to load |
| ctl_inc | input | 1 | Advance the combined pointer by one |
| bank_grant | output | 2 | Session granted, per bank port |
| bank_nack | output | 2 | Acknowledge-suppress pulse, per bank port |
| ctl_grant | output | 1 | Control session granted |
| ctl_nack | output | 1 | Control acknowledge-suppress pulse |
| wc_busy | output | 1 | Internal programming cycle running |
| mode_comb | output | 1 | 1 = combined mode, 0 = bank mode |
| mode_switch | output | 1 | One-cycle pulse on a mode change |
| ctl_ptr_valid | output | 1 | Combined pointer holds a loaded address |
| ctl_bank_sel | output | 1 | Bank selected by the combined pointer |
| ctl_word_addr | output | AW | Word address inside the selected bank |

## Verification
A session flag left set by mistake shows up one cycle after the next request, as a nack where a grant was due or as two grants that should exclude each other. The test sequence is built so that the request right after every state change is checked. A miscounted write-cycle timer shows up within one cycle at either end of the lockout, because `wc_busy` is sampled on its last busy cycle and on its first free cycle, and a poll falls inside the window. Pointer faults show up on the cycle after each load or increment across the 0FFh and 1FFh boundaries. A failure to invalidate shows up on `ctl_ptr_valid` when the mode switches back.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    MODE_BANK = 1'b0,
    MODE_COMB = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_wc_timer.sv
module arb_wc_timer #(
  parameter int WC_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = (WC_CYCLES > 1) ? $clog2(WC_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WC_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (kick) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_WC_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == '0 && !kick) |=> !busy); // R2
endmodule

// File: rtl/arb_comb_ptr.sv
module arb_comb_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inval,
  input  logic          load,
  input  logic [AW:0]   load_addr,
  input  logic          inc,
  output logic [AW:0]   addr,
  output logic          valid
);
  localparam logic [AW:0] LAST_LO  = {1'b0, {AW{1'b1}}};
  localparam logic [AW:0] FIRST_HI = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] LAST_HI  = {(AW+1){1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      valid <= 1'b0;
    end else if (inval) begin
      valid <= 1'b0;
    end else if (load) begin
      addr  <= load_addr;
      valid <= 1'b1;
    end else if (inc) begin
      addr  <= addr + 1'b1;
    end
  end

  AST_PTR_CROSS: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !inval && addr == LAST_LO) |=> addr == FIRST_HI); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !inval && addr == LAST_HI) |=> addr == '0); // R7
endmodule

// File: rtl/arb_bank_session.sv
module arb_bank_session (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wr,
  input  logic end_ev,
  input  logic flush,
  input  logic admit,
  output logic grant,
  output logic wr_q,
  output logic nack,
  output logic taken
);
  assign taken = start & admit;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      wr_q  <= 1'b0;
      nack  <= 1'b0;
    end else begin
      nack <= start & ~admit;
      if (flush)       grant <= 1'b0;
      else if (taken)  grant <= 1'b1;
      else if (end_ev) grant <= 1'b0;
      if (taken) wr_q <= wr;
    end
  end

  AST_NACK_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    nack |-> !grant); // R4
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (grant && end_ev && !start) |=> !grant); // R10
endmodule

// File: rtl/bank_port_arbiter.sv
module bank_port_arbiter
  import arb_pkg::*;
#(
  parameter int AW        = 8,
  parameter int WC_CYCLES = 250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bank_start,
  input  logic [1:0]    bank_wr,
  input  logic [1:0]    bank_end,
  input  logic [1:0]    bank_commit,
  input  logic          ctl_start,
  input  logic          ctl_wr,
  input  logic          ctl_end,
  input  logic          ctl_commit,
  input  logic          ctl_load,
  input  logic [AW:0]   ctl_load_addr,
  input  logic          ctl_inc,
  output logic [1:0]    bank_grant,
  output logic [1:0]    bank_nack,
  output logic          ctl_grant,
  output logic          ctl_nack,
  output logic          wc_busy,
  output logic          mode_comb,
  output logic          mode_switch,
  output logic          ctl_ptr_valid,
  output logic          ctl_bank_sel,
  output logic [AW-1:0] ctl_word_addr
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] bank_wr_q;
  logic [NPORT-1:0] bank_taken;
  logic             ctl_wr_q;
  logic             commit_any;
  logic             lock;
  logic             ctl_ok;
  logic             bank_admit;
  arb_mode_e        mode_q, mode_d;
  logic [AW:0]      ptr_addr;

  assign commit_any = (|(bank_commit & bank_grant & bank_wr_q))
                    | (ctl_commit & ctl_grant & ctl_wr_q);
  assign lock       = wc_busy | commit_any;
  assign ctl_ok     = ctl_start & ~lock & ~(|bank_grant);
  assign bank_admit = ~lock & ~ctl_grant & ~ctl_ok;

  generate
    for (genvar i = 0; i < NPORT; i++) begin : g_port
      arb_bank_session i_sess (
        .clk    (clk),
        .rst    (rst),
        .start  (bank_start[i]),
        .wr     (bank_wr[i]),
        .end_ev (bank_end[i]),
        .flush  (commit_any),
        .admit  (bank_admit),
        .grant  (bank_grant[i]),
        .wr_q   (bank_wr_q[i]),
        .nack   (bank_nack[i]),
        .taken  (bank_taken[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_grant <= 1'b0;
      ctl_wr_q  <= 1'b0;
      ctl_nack  <= 1'b0;
    end else begin
      ctl_nack <= ctl_start & ~ctl_ok;
      if (commit_any)   ctl_grant <= 1'b0;
      else if (ctl_ok)  ctl_grant <= 1'b1;
      else if (ctl_end) ctl_grant <= 1'b0;
      if (ctl_ok) ctl_wr_q <= ctl_wr;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (ctl_ok)           mode_d = MODE_COMB;
    else if (|bank_taken) mode_d = MODE_BANK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_BANK;
      mode_switch <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      mode_switch <= (mode_d != mode_q);
    end
  end

  assign mode_comb = (mode_q == MODE_COMB);

  arb_wc_timer #(.WC_CYCLES(WC_CYCLES)) i_timer (
    .clk  (clk),
    .rst  (rst),
    .kick (commit_any),
    .busy (wc_busy)
  );

  arb_comb_ptr #(.AW(AW)) i_ptr (
    .clk       (clk),
    .rst       (rst),
    .inval     (mode_d != mode_q),
    .load      (ctl_load & ctl_grant),
    .load_addr (ctl_load_addr),
    .inc       (ctl_inc & ctl_grant),
    .addr      (ptr_addr),
    .valid     (ctl_ptr_valid)
  );

  assign ctl_bank_sel  = ptr_addr[AW];
  assign ctl_word_addr = ptr_addr[AW-1:0];

  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (rst)
    wc_busy |-> (!ctl_grant && bank_grant == '0)); // R2
  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    commit_any |-> !wc_busy); // R2
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
    (wc_busy && ctl_start) |=> ctl_nack); // R3
  AST_CTL_EXCL: assert property (@(posedge clk) disable iff (rst)
    ctl_grant |-> bank_grant == '0); // R4
  AST_BANK_BLOCKS_CTL: assert property (@(posedge clk) disable iff (rst)
    (ctl_start && bank_grant != '0) |=> (ctl_nack && !ctl_grant)); // R5
  AST_TIE_CTL: assert property (@(posedge clk) disable iff (rst)
    (ctl_start && bank_start != '0 && !wc_busy && bank_grant == '0 && !ctl_grant)
      |=> (ctl_grant && bank_grant == '0)); // R9
  AST_SWITCH_INVAL: assert property (@(posedge clk) disable iff (rst)
    mode_switch |-> !ctl_ptr_valid); // R8
endmodule

// File: tb/test_bank_port_arbiter.sv
module test_bank_port_arbiter;
  localparam int AW = 8;
  localparam int WC = 10;

  localparam logic [18:0] M_ALL  = 19'h7FFFF;
  localparam logic [18:0] M_SESS = 19'h7E000;
  localparam logic [18:0] M_BUSY = 19'h01000;
  localparam logic [18:0] M_MODE = 19'h00C00;
  localparam logic [18:0] M_ADDR = 19'h003FF;
  localparam logic [18:0] M_PV   = 19'h00200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] bank_start = '0, bank_wr = '0, bank_end = '0, bank_commit = '0;
  logic ctl_start = 0, ctl_wr = 0, ctl_end = 0, ctl_commit = 0, ctl_load = 0, ctl_inc = 0;
  logic [AW:0] ctl_load_addr = '0;
  logic [1:0] bank_grant, bank_nack;
  logic ctl_grant, ctl_nack, wc_busy, mode_comb, mode_switch, ctl_ptr_valid, ctl_bank_sel;
  logic [AW-1:0] ctl_word_addr;

  always #10 clk = ~clk;

  bank_port_arbiter #(.AW(AW), .WC_CYCLES(WC)) i_bank_port_arbiter (
    .clk(clk), .rst(rst),
    .bank_start(bank_start), .bank_wr(bank_wr), .bank_end(bank_end), .bank_commit(bank_commit),
    .ctl_start(ctl_start), .ctl_wr(ctl_wr), .ctl_end(ctl_end), .ctl_commit(ctl_commit),
    .ctl_load(ctl_load), .ctl_load_addr(ctl_load_addr), .ctl_inc(ctl_inc),
    .bank_grant(bank_grant), .bank_nack(bank_nack), .ctl_grant(ctl_grant), .ctl_nack(ctl_nack),
    .wc_busy(wc_busy), .mode_comb(mode_comb), .mode_switch(mode_switch),
    .ctl_ptr_valid(ctl_ptr_valid), .ctl_bank_sel(ctl_bank_sel), .ctl_word_addr(ctl_word_addr)
  );

  typedef struct {
    int          cyc;
    logic [18:0] mask;
    logic [18:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [18:0] pk(logic [1:0] g, logic cg, logic [1:0] n, logic cn,
                                     logic busy, logic mc, logic ms, logic pv,
                                     logic bs, logic [7:0] w);
    return {g, cg, n, cn, busy, mc, ms, pv, bs, w};
  endfunction

  wire [18:0] obs = {bank_grant, ctl_grant, bank_nack, ctl_nack, wc_busy,
                     mode_comb, mode_switch, ctl_ptr_valid, ctl_bank_sel, ctl_word_addr};

  // monitor: compares expected items as the design produces them
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if ((obs & e.mask) !== (e.val & e.mask)) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h (mask %h)", e.tag,
                 obs & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  task automatic expect_next(string tag, logic [18:0] m, logic [18:0] v);
    q.push_back('{cyc + 1, m, v, tag});
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    bank_start = '0; bank_end = '0; bank_commit = '0;
    ctl_start = 0; ctl_end = 0; ctl_commit = 0; ctl_load = 0; ctl_inc = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    expect_next("R8 reset state", M_ALL, pk(0,0,0,0,0,0,0,0,0,8'h00)); tick();

    bank_start = 2'b11; bank_wr = 2'b00;
    expect_next("R1 concurrent reads", M_SESS, pk(2'b11,0,0,0,0,0,0,0,0,0)); tick();

    ctl_start = 1;
    expect_next("R5 ctl refused during bank session", M_SESS, pk(2'b11,0,0,1,0,0,0,0,0,0)); tick();

    bank_end = 2'b01;
    expect_next("R10 port1 end", M_SESS, pk(2'b10,0,0,0,0,0,0,0,0,0)); tick();
    bank_end = 2'b10;
    expect_next("R10 port2 end", M_SESS, pk(2'b00,0,0,0,0,0,0,0,0,0)); tick();

    ctl_start = 1; bank_start = 2'b01;
    expect_next("R9 tie to ctl, R8 switch", M_SESS | M_MODE | M_PV,
                pk(2'b00,1,2'b01,0,0,1,1,0,0,0)); tick();

    bank_start = 2'b10;
    expect_next("R4 bank refused during ctl", M_SESS, pk(2'b00,1,2'b10,0,0,0,0,0,0,0)); tick();

    ctl_load = 1; ctl_load_addr = 9'h0FF;
    expect_next("R6 load 0FFh", M_ADDR, pk(0,0,0,0,0,0,0,1,0,8'hFF)); tick();
    ctl_inc = 1;
    expect_next("R7 0FFh to 100h", M_ADDR, pk(0,0,0,0,0,0,0,1,1,8'h00)); tick();
    ctl_load = 1; ctl_load_addr = 9'h1FF;
    expect_next("R6 load 1FFh", M_ADDR, pk(0,0,0,0,0,0,0,1,1,8'hFF)); tick();
    ctl_inc = 1;
    expect_next("R7 1FFh wraps", M_ADDR, pk(0,0,0,0,0,0,0,1,0,8'h00)); tick();

    ctl_start = 1; ctl_wr = 1;
    expect_next("R10 ctl restart for write", M_SESS, pk(0,1,0,0,0,0,0,0,0,0)); tick();
    ctl_commit = 1;
    expect_next("R2 commit starts busy", M_SESS | M_BUSY, pk(0,0,0,0,1,0,0,0,0,0)); tick();

    bank_start = 2'b01; bank_wr = 2'b00;
    expect_next("R3 bank poll while busy", M_SESS | M_BUSY, pk(0,0,2'b01,0,1,0,0,0,0,0)); tick();
    ctl_start = 1; ctl_wr = 0;
    expect_next("R3 ctl poll while busy", M_SESS | M_BUSY, pk(0,0,0,1,1,0,0,0,0,0)); tick();
    repeat (6) tick();
    expect_next("R2 last busy cycle", M_BUSY, pk(0,0,0,0,1,0,0,0,0,0)); tick();
    expect_next("R2 busy released", M_BUSY, pk(0,0,0,0,0,0,0,0,0,0)); tick();

    bank_start = 2'b01;
    expect_next("R3 R8 first poll granted, ptr invalid", M_SESS | M_MODE | M_PV,
                pk(2'b01,0,0,0,0,0,1,0,0,0)); tick();
    bank_end = 2'b01; tick();

    bank_start = 2'b11; bank_wr = 2'b01;
    expect_next("R1 write and read granted", M_SESS, pk(2'b11,0,0,0,0,0,0,0,0,0)); tick();
    bank_commit = 2'b01;
    expect_next("R2 commit drops other port", M_SESS | M_BUSY, pk(0,0,0,0,1,0,0,0,0,0)); tick();

    tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule